// File: doc/BRIEF.md
# Bridge excitation sequencer with offset-cancelling pair averaging

The block drives an external four-transistor H-bridge that excites a resistive sensor bridge with alternating polarity. In the forward phase one transistor pair feeds the top of the bridge. In the reverse phase the opposite pair feeds the bottom, so the sensor signal and the converter reference are both inverted. The two pairs never conduct together. Between releasing one pair and turning on the other, a dead time of `DEAD_CYC` clocks with every switch off is inserted.

After each pair turns on, the block waits for the analog input to settle before it asks the converter core for a conversion. The wait is 200 µs, or 100 µs when `fast_mode` is set for the highest output rate. It is counted in clocks derived from `CLK_HZ`. One conversion is taken in each phase. The raw forward and reverse codes are summed and halved into one result. Because the reference flips with the input, no negation is needed, and DC offsets that do not follow the excitation cancel out. The converter therefore delivers one result for every forward/reverse pair.

The result leaves on a valid/ready stream. `avg_valid` and `avg_data` hold until the cycle in which `avg_ready` is high, and the slot is free again in that same cycle. If a pair finishes while the slot still holds an unaccepted result, the sequencer stays in the reverse phase and issues no conversion until the slot frees. The converter handshake and the drive outputs are plain control pins.

Top module: `bridge_exc_seq`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and in every cycle after reset until enable is sampled high, drv_fwd and drv_rev are 0, drv_fwd_n and drv_rev_n are 1, conv_req is 0 and avg_valid is 0.
- R2: drv_fwd_n is always the inverse of drv_fwd, and drv_rev_n is always the inverse of drv_rev (all drives active-high as named).
- R3: drv_fwd and drv_rev are never 1 in the same cycle. Each phase change while enabled leaves both off for exactly DEAD_CYC cycles.
- R4: After enable is first sampled high, every drive stays off for DEAD_CYC+1 cycles, and the forward pair is the first to turn on.
- R5: conv_req rises exactly N cycles after a pair turns on. N is CLK_HZ*200/10^6 cycles, or CLK_HZ*100/10^6 when fast_mode was high at the clock edge that turned the pair on.
- R6: conv_req stays high, with exactly one pair on, until conv_done is sampled high. It falls at the next edge.
- R7: Phases alternate forward, reverse, forward, and so on, with one conversion in each.
- R8: Each result is floor((F+R)/2) of the forward code F and the reverse code R, all DW-bit two's complement. It is exact at both ends of the code range.
- R9: avg_valid and avg_data hold while avg_ready is low. A pair that completes while the slot is full keeps the reverse pair on and requests no conversion until the slot frees.
- R10: When enable is sampled low, all drives are off and conv_req is 0 from the next cycle on. A partly collected pair is dropped, while an unaccepted result stays valid.
- R11: conv_done pulses while conv_req is low have no effect on the drives, conv_req or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the excitation sequence; low forces all switches off |
| fast_mode | input | 1 | Use the short settle delay (highest output rate) |
| conv_req | output | 1 | Conversion request to the converter core, held until done |
| conv_done | input | 1 | One-cycle conversion complete strobe |
| conv_code | input | DW | Signed raw conversion code, valid with conv_done |
| drv_fwd | output | 1 | Forward-phase transistor pair on |
| drv_fwd_n | output | 1 | Inverse of drv_fwd |
| drv_rev | output | 1 | Reverse-phase transistor pair on |
| drv_rev_n | output | 1 | Inverse of drv_rev |
| avg_data | output | DW | Signed pair-averaged result |
| avg_valid | output | 1 | avg_data holds a result |
| avg_ready | input | 1 | Consumer accepts avg_data this cycle |

## Verification
The sequencer runs with the long and then the short settle delay, and with converter latencies that vary from one request to the next. This separates settle counting from handshake timing. The forward/reverse code pairs include a symmetric offset, odd negative sums and both range extremes. These catch a wrong sign correction, truncation toward zero instead of floor, and sum overflow. Long stretches of low `avg_ready` force the hold in the reverse phase. A stray done strobe during settling, and a disable in the middle of a reverse phase, show whether out-of-turn events disturb the drive sequence or the pending result.

// File: rtl/bexc_pkg.sv
package bexc_pkg;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_GAP,
    SQ_SETTLE,
    SQ_CONV,
    SQ_HOLD
  } sq_state_t;

  // Microseconds to clock cycles, never below one cycle.
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input int unsigned us);
    longint unsigned c;
    c = (clk_hz * 64'(us)) / 64'd1000000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bexc_timer.sv
module bexc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          zero
);
  logic [TW-1:0] cnt;

  // A load of len gives len cycles before zero (len >= 1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= len - TW'(1);
    else if (cnt != '0)     cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bexc_drive.sv
module bexc_drive
  import bexc_pkg::*;
(
  input  sq_state_t  st,
  input  logic       ph_rev,
  output logic [1:0] on,
  output logic [1:0] on_n
);
  logic live;

  assign live = (st == SQ_SETTLE) || (st == SQ_CONV) || (st == SQ_HOLD);

  // Index 0: forward pair, index 1: reverse pair.
  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign on[p]   = live && (ph_rev == 1'(p));
    assign on_n[p] = ~on[p];
  end
endmodule

// File: rtl/bexc_pair_avg.sv
module bexc_pair_avg #(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_fwd,
  input  logic                 cap_rev,
  input  logic signed [DW-1:0] code,
  input  logic                 push,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid,
  output logic                 slot_free
);
  logic signed [DW-1:0] fwd_q, rev_q;
  logic signed [DW:0]   sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= '0;
      rev_q <= '0;
    end else begin
      if (cap_fwd) fwd_q <= code;
      if (cap_rev) rev_q <= code;
    end
  end

  // One guard bit keeps the sum exact; dropping the low bit floors it.
  assign sum       = {fwd_q[DW-1], fwd_q} + {rev_q[DW-1], rev_q};
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (push) begin
      out_data  <= sum[DW:1];
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_exc_seq.sv
module bridge_exc_seq
  import bexc_pkg::*;
#(
  parameter int          DW             = 24,
  parameter int unsigned CLK_HZ         = 125_000_000,
  parameter int unsigned SETTLE_US      = 200,
  parameter int unsigned FAST_SETTLE_US = 100,
  parameter int unsigned DEAD_CYC       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 fast_mode,
  output logic                 conv_req,
  input  logic                 conv_done,
  input  logic signed [DW-1:0] conv_code,
  output logic                 drv_fwd,
  output logic                 drv_fwd_n,
  output logic                 drv_rev,
  output logic                 drv_rev_n,
  output logic signed [DW-1:0] avg_data,
  output logic                 avg_valid,
  input  logic                 avg_ready
);
  localparam int unsigned SLOW_CYC = us_to_cycles(64'(CLK_HZ), SETTLE_US);
  localparam int unsigned FAST_CYC = us_to_cycles(64'(CLK_HZ), FAST_SETTLE_US);
  localparam int unsigned TOP_CYC  = max3(SLOW_CYC, FAST_CYC, DEAD_CYC);
  localparam int          TW       = $clog2(TOP_CYC + 1);

  sq_state_t     st, st_d;
  logic          ph_rev, ph_rev_d;
  logic          ld;
  logic [TW-1:0] ld_len;
  logic          tmr_zero;
  logic          cap_fwd, cap_rev, push, slot_free;
  logic [1:0]    on, on_n;

  always_comb begin
    st_d     = st;
    ph_rev_d = ph_rev;
    ld       = 1'b0;
    ld_len   = TW'(DEAD_CYC);
    cap_fwd  = 1'b0;
    cap_rev  = 1'b0;
    push     = 1'b0;
    if (!enable) begin
      st_d     = SQ_OFF;
      ph_rev_d = 1'b0;
    end else begin
      unique case (st)
        SQ_OFF: begin
          st_d     = SQ_GAP;
          ph_rev_d = 1'b0;
          ld       = 1'b1;
        end
        SQ_GAP: begin
          if (tmr_zero) begin
            st_d   = SQ_SETTLE;
            ld     = 1'b1;
            ld_len = fast_mode ? TW'(FAST_CYC) : TW'(SLOW_CYC);
          end
        end
        SQ_SETTLE: begin
          if (tmr_zero) st_d = SQ_CONV;
        end
        SQ_CONV: begin
          if (conv_done) begin
            if (!ph_rev) begin
              cap_fwd  = 1'b1;
              ph_rev_d = 1'b1;
              st_d     = SQ_GAP;
              ld       = 1'b1;
            end else begin
              cap_rev = 1'b1;
              st_d    = SQ_HOLD;
            end
          end
        end
        SQ_HOLD: begin
          if (slot_free) begin
            push     = 1'b1;
            ph_rev_d = 1'b0;
            st_d     = SQ_GAP;
            ld       = 1'b1;
          end
        end
        default: st_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_OFF;
      ph_rev <= 1'b0;
    end else begin
      st     <= st_d;
      ph_rev <= ph_rev_d;
    end
  end

  bexc_timer #(.TW(TW)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ld),
    .len   (ld_len),
    .zero  (tmr_zero)
  );

  bexc_drive drv_i (
    .st     (st),
    .ph_rev (ph_rev),
    .on     (on),
    .on_n   (on_n)
  );

  bexc_pair_avg #(.DW(DW)) avg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_fwd   (cap_fwd),
    .cap_rev   (cap_rev),
    .code      (conv_code),
    .push      (push),
    .out_ready (avg_ready),
    .out_data  (avg_data),
    .out_valid (avg_valid),
    .slot_free (slot_free)
  );

  assign conv_req  = (st == SQ_CONV);
  assign drv_fwd   = on[0];
  assign drv_rev   = on[1];
  assign drv_fwd_n = on_n[0];
  assign drv_rev_n = on_n[1];
endmodule

// File: rtl/bexc_seq_chk.sv
module bexc_seq_chk #(
  parameter int DW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 conv_req,
  input logic                 conv_done,
  input logic                 drv_fwd,
  input logic                 drv_rev,
  input logic signed [DW-1:0] avg_data,
  input logic                 avg_valid,
  input logic                 avg_ready
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_fwd && drv_rev));

  // R3
  fwd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_fwd) |-> !drv_rev);

  // R3
  rev_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_rev) |-> !drv_fwd);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && conv_req && !conv_done) |=> conv_req);

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> !conv_req);

  // R6
  req_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (drv_fwd ^ drv_rev));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_valid && !avg_ready) |=> (avg_valid && $stable(avg_data)));

  // R10
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drv_fwd && !drv_rev && !conv_req));
endmodule

bind bridge_exc_seq bexc_seq_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .conv_req  (conv_req),
  .conv_done (conv_done),
  .drv_fwd   (drv_fwd),
  .drv_rev   (drv_rev),
  .avg_data  (avg_data),
  .avg_valid (avg_valid),
  .avg_ready (avg_ready)
);

// File: tb/bridge_exc_seq_tb_top.sv
module bridge_exc_seq_tb_top;
  localparam int DW    = 24;
  localparam int DEAD  = 3;
  localparam int SLOW  = 20;   // 200 us at 100 kHz timing base
  localparam int FAST  = 10;   // 100 us
  localparam int MAXC  = (1 << (DW - 1)) - 1;
  localparam int MINC  = -(1 << (DW - 1));

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, fast_mode = 1'b0, conv_done = 1'b0, avg_ready = 1'b0;
  logic signed [DW-1:0] conv_code = '0;
  logic conv_req, drv_fwd, drv_fwd_n, drv_rev, drv_rev_n, avg_valid;
  logic signed [DW-1:0] avg_data;

  bridge_exc_seq #(
    .DW(DW), .CLK_HZ(100_000), .SETTLE_US(200), .FAST_SETTLE_US(100), .DEAD_CYC(DEAD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .conv_req(conv_req), .conv_done(conv_done), .conv_code(conv_code),
    .drv_fwd(drv_fwd), .drv_fwd_n(drv_fwd_n), .drv_rev(drv_rev), .drv_rev_n(drv_rev_n),
    .avg_data(avg_data), .avg_valid(avg_valid), .avg_ready(avg_ready)
  );

  int checks = 0, failures = 0, n_out = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int floor2(input int s);
    return (s >= 0) ? s / 2 : -((1 - s) / 2);
  endfunction

  function automatic logic signed [DW-1:0] code_of(input int k, input bit rev);
    int v;
    case (k % 6)
      0: v = rev ? 95 : 105;
      1: v = rev ? 0 : -3;
      2: v = MAXC;
      3: v = MINC;
      4: v = rev ? MAXC : MINC;
      default: v = rev ? (2 - 3 * k) : (1000 * k - 7);
    endcase
    return DW'(v);
  endfunction

  // Behavioural reference: segment 0 off, 1 gap, 2 settle, 3 convert, 4 hold.
  int m_seg = 0, m_ph = 0, m_left = 0, m_a = 0, m_b = 0, m_od = 0;
  bit m_ov = 0, m_had = 0;
  bit en_q = 0, fq = 0;

  always @(posedge clk) begin
    en_q <= enable;
    fq   <= fast_mode;
    if (!rst_n) begin
      m_seg = 0; m_ph = 0; m_left = 0; m_ov = 0; m_od = 0;
    end else begin
      m_had = m_ov;
      if (m_ov && avg_ready) m_ov = 0;
      if (!enable) begin
        m_seg = 0; m_ph = 0;
      end else begin
        case (m_seg)
          0: begin m_seg = 1; m_ph = 0; m_left = DEAD; end
          1: begin
            m_left--;
            if (m_left == 0) begin m_seg = 2; m_left = fast_mode ? FAST : SLOW; end
          end
          2: begin m_left--; if (m_left == 0) m_seg = 3; end
          3: if (conv_done) begin
            if (m_ph == 0) begin
              m_a = int'(conv_code); m_ph = 1; m_seg = 1; m_left = DEAD;
            end else begin
              m_b = int'(conv_code); m_seg = 4;
            end
          end
          default: if (!m_had || avg_ready) begin
            m_od = floor2(m_a + m_b); m_ov = 1; m_ph = 0; m_seg = 1; m_left = DEAD;
          end
        endcase
      end
    end
  end

  // Converter core stand-in with varying latency.
  int em_wait = -1, em_cnt = 0, em_pair = 0;
  bit em_rev = 0, stray_req = 0;

  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (stray_req && !conv_req) begin
      conv_done <= 1'b1;
      conv_code <= DW'(12345);
      stray_req = 0;
    end else if (!conv_req) begin
      em_wait = -1;
    end else if (em_wait == -1) begin
      em_rev  = drv_rev;
      em_wait = 1 + (em_cnt % 4);
      em_cnt++;
    end else if (em_wait == 0) begin
      conv_done <= 1'b1;
      conv_code <= code_of(em_pair, em_rev);
      if (em_rev) em_pair++;
      em_wait = -2;
    end else if (em_wait > 0) begin
      em_wait--;
    end
  end

  // Per-cycle comparison and timing monitors.
  bit p_fwd = 0, p_rev = 0, p_req = 0, exp_rev = 0, st_arm = 0, g_arm = 0;
  int st_cnt = 0, st_exp = 0, g_cnt = 0;
  bit mf, mr;

  always @(negedge clk) begin
    cyc++;
    mf = (m_seg >= 2) && (m_ph == 0);
    mr = (m_seg >= 2) && (m_ph == 1);
    chk(drv_fwd === mf, "R4 R7 R10 drv_fwd", drv_fwd, mf);
    chk(drv_rev === mr, "R4 R7 R9 R10 drv_rev", drv_rev, mr);
    chk(conv_req === (m_seg == 3), "R5 R6 R11 conv_req", conv_req, m_seg == 3);
    chk(avg_valid === m_ov, "R9 avg_valid", avg_valid, m_ov);
    if (m_ov) chk(int'(avg_data) == m_od, "R8 avg_data", int'(avg_data), m_od);
    chk(drv_fwd_n === ~drv_fwd && drv_rev_n === ~drv_rev, "R2 complement drives",
        {drv_fwd_n, drv_rev_n}, {~drv_fwd, ~drv_rev});
    chk(!(drv_fwd && drv_rev), "R3 pair overlap", {drv_fwd, drv_rev}, 0);
    if (avg_valid && avg_ready) n_out++;

    // R7 phase order
    if (drv_fwd && !p_fwd) begin
      chk(!exp_rev, "R7 forward turned on out of turn", 1, 0);
      exp_rev = 1;
    end
    if (drv_rev && !p_rev) begin
      chk(exp_rev, "R7 reverse turned on out of turn", 0, 1);
      exp_rev = 0;
    end

    // R5 settle length
    if ((drv_fwd && !p_fwd) || (drv_rev && !p_rev)) begin
      st_arm = 1; st_cnt = 0; st_exp = fq ? FAST : SLOW;
    end else if (st_arm) begin
      st_cnt++;
      if (conv_req && !p_req) begin
        chk(st_cnt == st_exp, "R5 settle length", st_cnt, st_exp);
        st_arm = 0;
      end
    end

    // R3 dead time between phases
    if ((!drv_fwd && p_fwd) || (!drv_rev && p_rev)) begin
      if (en_q) begin g_arm = 1; g_cnt = 0; end
    end else if (g_arm) begin
      g_cnt++;
      if (drv_fwd || drv_rev) begin
        chk(g_cnt == DEAD, "R3 dead time", g_cnt, DEAD);
        g_arm = 0;
      end
    end

    if (!en_q) begin exp_rev = 0; st_arm = 0; g_arm = 0; end
    p_fwd = drv_fwd; p_rev = drv_rev; p_req = conv_req;
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic wait_out(input int n);
    while (n_out < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!drv_fwd && !drv_rev && drv_fwd_n && drv_rev_n && !conv_req && !avg_valid,
        "R1 reset outputs", {drv_fwd, drv_rev, conv_req, avg_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after reset, still disabled
    chk(!drv_fwd && !drv_rev && !conv_req && !avg_valid,
        "R1 idle outputs", {drv_fwd, drv_rev, conv_req, avg_valid}, 0);

    // Long settle delay, free-flowing output (R4 start, R8 codes)
    avg_ready = 1'b1;
    enable    = 1'b1;
    wait_out(4);

    // Short settle delay (R5)
    fast_mode = 1'b1;
    wait_out(7);

    // Back-pressure: long stalls force the reverse-phase hold (R9)
    while (n_out < 10) begin
      @(negedge clk);
      avg_ready = (cyc % 65) >= 60;
    end
    avg_ready = 1'b1;
    fast_mode = 1'b0;

    // R11: stray done strobe while the forward pair settles
    while (!(drv_fwd && !conv_req)) @(negedge clk);
    repeat (2) @(negedge clk);
    stray_req = 1;
    wait_out(11);

    // R10: drop enable in the middle of the reverse phase
    while (!drv_rev) @(negedge clk);
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!drv_fwd && !drv_rev && !conv_req, "R10 disable forces off",
        {drv_fwd, drv_rev, conv_req}, 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    wait_out(13);
    repeat (5) @(negedge clk);

    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", n_out, 13);
      report();
      $finish;
    end
  end
endmodule